// File: doc/BRIEF.md
# 8-bit CPU bus cycle classifier

This block watches the active-low control strobes, the 16-bit address bus and the 8-bit data bus of an 8-bit microprocessor. It samples them on every edge of a free-running capture clock. Each sample is sorted into one of seven bus-cycle kinds. Whenever the bus leaves or enters the idle state, and whenever it jumps between two active kinds without passing through idle, the block raises a one-clock event. A trace or debug unit placed beside the processor bus uses these events to tell where each bus transaction starts and ends. It also gets the address that opened the transaction, the last data byte the transaction carried, and whether that byte was a memory or an I/O transfer.

The inputs are expected to be already synchronous to the capture clock. Synchronisation and glitch filtering happen upstream of this block. Every event is registered: it appears in the clock after the sample that caused it and lasts exactly one clock.

Top module: `bus_cycle_classifier`

## Requirements
- R1: With `mem_sel_n` low, a sample is kind 5 (opcode fetch) when `read_n` and `first_n` are both low, and kind 1 (memory read) when `read_n` is low and `first_n` is high. Otherwise it is kind 2 (memory write) when `write_n` is low. Memory selection takes priority over `io_sel_n`.
- R2: With `mem_sel_n` high and `io_sel_n` low, a sample is kind 6 (interrupt acknowledge) when `first_n` is low. Otherwise it is kind 3 (I/O read) when `read_n` is low, or kind 4 (I/O write) when `write_n` is low.
- R3: A sample with no qualifying strobe combination is kind 0 (idle). This includes a select line with neither `read_n` nor `write_n` low, and it raises no event.
- R4: A move from idle to any active kind raises `begin_pls`. The same clock shows the sampled address on `begin_addr` and sets `addr_pend`.
- R5: A move from an active kind to idle raises `end_pls`. `end_data` then shows the data byte of the last active sample.
- R6: With `end_pls`, `end_kind` shows the kind that was active before idle, and `addr_pend` clears.
- R7: A move from one active kind straight to a different active kind raises `bad_pls` and clears `addr_pend`. It raises neither `begin_pls` nor `end_pls`.
- R8: With `end_pls`, `end_cat` gives the data category: 0 memory read (kinds 1 and 5), 1 memory write (kind 2), 2 I/O read (kinds 3 and 6), 3 I/O write (kind 4).
- R9: Each event is a single-clock pulse, registered in the clock after the causing sample. An unchanged active kind over consecutive samples raises no event.
- R10: A synchronous active-high `rst` forces the previous kind to idle and clears all event outputs and `addr_pend`. An active kind still present after reset is therefore seen as a fresh begin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock |
| rst | input | 1 | Synchronous active-high reset |
| first_n | input | 1 | Active-low first-machine-cycle strobe |
| read_n | input | 1 | Active-low read strobe |
| write_n | input | 1 | Active-low write strobe |
| mem_sel_n | input | 1 | Active-low memory request |
| io_sel_n | input | 1 | Active-low I/O request |
| addr_in | input | AW | Address bus |
| data_in | input | DW | Data bus |
| begin_pls | output | 1 | Cycle begin event |
| begin_addr | output | AW | Address captured at begin |
| addr_pend | output | 1 | A begun cycle has not yet ended or been broken |
| end_pls | output | 1 | Cycle end event |
| end_kind | output | 3 | Kind of the cycle that ended |
| end_data | output | DW | Last data byte of the ended cycle |
| end_cat | output | 2 | Data category of the ended cycle |
| bad_pls | output | 1 | Illegal direct transition event |

## Verification
A table-driven run passes each of the six active kinds through a begin, hold and end. For each one it checks the reported kind, the category and the last data byte. Together these separate the fetch/read and acknowledge/read pairs, which differ only in `first_n`, and show that the byte kept is the final one rather than the first. Samples where both selects are low show the memory-over-I/O priority, and samples where a select has no strobe show the idle decode. Direct jumps between memory kinds, and between acknowledge and I/O read, exercise the error pulse and the dropped pending address. A reset applied during an active cycle shows that the held cycle reappears as a new begin.

// File: rtl/bus_cycle_classifier.sv
module bus_cycle_classifier #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          first_n,
  input  logic          read_n,
  input  logic          write_n,
  input  logic          mem_sel_n,
  input  logic          io_sel_n,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] data_in,
  output logic          begin_pls,
  output logic [AW-1:0] begin_addr,
  output logic          addr_pend,
  output logic          end_pls,
  output logic [2:0]    end_kind,
  output logic [DW-1:0] end_data,
  output logic [1:0]    end_cat,
  output logic          bad_pls
);

  typedef enum logic [2:0] {
    K_IDLE = 3'd0, K_MRD = 3'd1, K_MWR = 3'd2, K_IRD = 3'd3,
    K_IWR  = 3'd4, K_OPF = 3'd5, K_IACK = 3'd6
  } kind_e;

  kind_e now_kind, last_kind;
  logic [DW-1:0] data_q;

  always_comb begin
    now_kind = K_IDLE;
    if (!mem_sel_n) begin
      if (!read_n)       now_kind = first_n ? K_MRD : K_OPF;
      else if (!write_n) now_kind = K_MWR;
    end else if (!io_sel_n) begin
      if (!first_n)      now_kind = K_IACK;
      else if (!read_n)  now_kind = K_IRD;
      else if (!write_n) now_kind = K_IWR;
    end
  end

  wire act_now  = (now_kind != K_IDLE);
  wire act_last = (last_kind != K_IDLE);
  wire go_begin = !act_last && act_now;
  wire go_end   = act_last && !act_now;
  wire go_bad   = act_last && act_now && (now_kind != last_kind);

  function automatic logic [1:0] cat_of(kind_e k);
    case (k)
      K_MWR:         return 2'd1;
      K_IRD, K_IACK: return 2'd2;
      K_IWR:         return 2'd3;
      default:       return 2'd0;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      last_kind  <= K_IDLE;
      begin_pls  <= 1'b0;
      end_pls    <= 1'b0;
      bad_pls    <= 1'b0;
      addr_pend  <= 1'b0;
      begin_addr <= '0;
      end_kind   <= 3'd0;
      end_data   <= '0;
      end_cat    <= 2'd0;
      data_q     <= '0;
    end else begin
      last_kind <= now_kind;
      begin_pls <= go_begin;
      end_pls   <= go_end;
      bad_pls   <= go_bad;
      if (act_now) data_q <= data_in;
      if (go_begin) begin
        begin_addr <= addr_in;
        addr_pend  <= 1'b1;
      end else if (go_end || go_bad) begin
        addr_pend  <= 1'b0;
      end
      if (go_end) begin
        end_kind <= last_kind;
        end_data <= data_q;
        end_cat  <= cat_of(last_kind);
      end
    end
  end

  a_r4_begin_addr: assert property (@(posedge clk) disable iff (rst)
    begin_pls |-> (begin_addr == $past(addr_in)) && addr_pend);
  a_r5_end_data: assert property (@(posedge clk) disable iff (rst)
    end_pls |-> end_data == $past(data_in, 2));
  a_r6_end_kind: assert property (@(posedge clk) disable iff (rst)
    end_pls |-> (end_kind != 3'd0) && !addr_pend);
  a_r7_bad_drops: assert property (@(posedge clk) disable iff (rst)
    bad_pls |-> !addr_pend && !begin_pls && !end_pls);
  a_r9_one_shot: assert property (@(posedge clk) disable iff (rst)
    end_pls |=> !end_pls);
  a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
    $countones({begin_pls, end_pls, bad_pls}) <= 1);
  a_r10_reset: assert property (@(posedge clk)
    rst |=> !begin_pls && !end_pls && !bad_pls && !addr_pend);

endmodule

// File: tb/bus_cycle_classifier_tb.sv
module bus_cycle_classifier_tb;
  logic clk = 1'b0, rst = 1'b1;
  logic first_n, read_n, write_n, mem_sel_n, io_sel_n;
  logic [15:0] addr_in;
  logic [7:0]  data_in;
  logic begin_pls, addr_pend, end_pls, bad_pls;
  logic [15:0] begin_addr;
  logic [2:0]  end_kind;
  logic [7:0]  end_data;
  logic [1:0]  end_cat;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bus_cycle_classifier u_dut (
    .clk(clk), .rst(rst), .first_n(first_n), .read_n(read_n), .write_n(write_n),
    .mem_sel_n(mem_sel_n), .io_sel_n(io_sel_n), .addr_in(addr_in), .data_in(data_in),
    .begin_pls(begin_pls), .begin_addr(begin_addr), .addr_pend(addr_pend),
    .end_pls(end_pls), .end_kind(end_kind), .end_data(end_data),
    .end_cat(end_cat), .bad_pls(bad_pls));

  // control order {first_n, read_n, write_n, mem_sel_n, io_sel_n}
  localparam logic [4:0] C_IDLE = 5'b11111, C_OPF = 5'b00101, C_MRD = 5'b10101,
    C_MWR = 5'b11001, C_IRD = 5'b10110, C_IWR = 5'b11010, C_IACK = 5'b01110,
    C_BOTH = 5'b10100, C_MNOS = 5'b11101, C_INOS = 5'b11110;

  typedef struct packed {
    logic [4:0] c; logic [7:0] d;
    logic b, e, x, p; logic [2:0] k; logic [7:0] ed;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t TAB [NV] = '{
    '{C_IDLE, 8'h00, 1'b0,1'b0,1'b0,1'b0, 3'd0, 8'h00},
    '{C_OPF,  8'h3E, 1'b1,1'b0,1'b0,1'b1, 3'd0, 8'h00}, // R1 fetch
    '{C_OPF,  8'h3F, 1'b0,1'b0,1'b0,1'b1, 3'd0, 8'h00}, // R9 held kind silent
    '{C_IDLE, 8'h00, 1'b0,1'b1,1'b0,1'b0, 3'd5, 8'h3F}, // R5 last byte
    '{C_MRD,  8'h11, 1'b1,1'b0,1'b0,1'b1, 3'd0, 8'h00},
    '{C_IDLE, 8'h00, 1'b0,1'b1,1'b0,1'b0, 3'd1, 8'h11},
    '{C_MWR,  8'h22, 1'b1,1'b0,1'b0,1'b1, 3'd0, 8'h00},
    '{C_MWR,  8'h23, 1'b0,1'b0,1'b0,1'b1, 3'd0, 8'h00},
    '{C_IDLE, 8'h00, 1'b0,1'b1,1'b0,1'b0, 3'd2, 8'h23},
    '{C_IRD,  8'h44, 1'b1,1'b0,1'b0,1'b1, 3'd0, 8'h00}, // R2
    '{C_IDLE, 8'h00, 1'b0,1'b1,1'b0,1'b0, 3'd3, 8'h44},
    '{C_IWR,  8'h55, 1'b1,1'b0,1'b0,1'b1, 3'd0, 8'h00},
    '{C_IDLE, 8'h00, 1'b0,1'b1,1'b0,1'b0, 3'd4, 8'h55},
    '{C_IACK, 8'h66, 1'b1,1'b0,1'b0,1'b1, 3'd0, 8'h00},
    '{C_IDLE, 8'h00, 1'b0,1'b1,1'b0,1'b0, 3'd6, 8'h66},
    '{C_BOTH, 8'h78, 1'b1,1'b0,1'b0,1'b1, 3'd0, 8'h00}, // R1 memory priority
    '{C_IDLE, 8'h00, 1'b0,1'b1,1'b0,1'b0, 3'd1, 8'h78},
    '{C_MRD,  8'h80, 1'b1,1'b0,1'b0,1'b1, 3'd0, 8'h00},
    '{C_MWR,  8'h81, 1'b0,1'b0,1'b1,1'b0, 3'd0, 8'h00}, // R7
    '{C_MWR,  8'h82, 1'b0,1'b0,1'b0,1'b0, 3'd0, 8'h00},
    '{C_IDLE, 8'h00, 1'b0,1'b1,1'b0,1'b0, 3'd2, 8'h82},
    '{C_OPF,  8'h90, 1'b1,1'b0,1'b0,1'b1, 3'd0, 8'h00},
    '{C_MRD,  8'h91, 1'b0,1'b0,1'b1,1'b0, 3'd0, 8'h00},
    '{C_IDLE, 8'h00, 1'b0,1'b1,1'b0,1'b0, 3'd1, 8'h91},
    '{C_IDLE, 8'h00, 1'b0,1'b0,1'b0,1'b0, 3'd0, 8'h00},
    '{C_IACK, 8'hA5, 1'b1,1'b0,1'b0,1'b1, 3'd0, 8'h00},
    '{C_IRD,  8'hA6, 1'b0,1'b0,1'b1,1'b0, 3'd0, 8'h00},
    '{C_IDLE, 8'h00, 1'b0,1'b1,1'b0,1'b0, 3'd3, 8'hA6}
  };

  function automatic logic [1:0] exp_cat(logic [2:0] k); // R8 mapping
    case (k)
      3'd2: return 2'd1;
      3'd3, 3'd6: return 2'd2;
      3'd4: return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [4:0] c, input logic [15:0] a, input logic [7:0] d);
    {first_n, read_n, write_n, mem_sel_n, io_sel_n} = c;
    addr_in = a;
    data_in = d;
  endtask

  task automatic step_check;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (4000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    drive(C_IDLE, 16'h0, 8'h0);
    repeat (2) @(posedge clk);
    #1;
    chk("R10", "begin after reset", int'(begin_pls), 0);
    chk("R10", "end after reset", int'(end_pls), 0);
    chk("R10", "bad after reset", int'(bad_pls), 0);
    chk("R10", "pend after reset", int'(addr_pend), 0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [15:0] a;
      a = 16'(32'h1000 + i * 273);
      @(negedge clk);
      drive(TAB[i].c, a, TAB[i].d);
      step_check();
      chk("R4", $sformatf("begin v%0d", i), int'(begin_pls), int'(TAB[i].b));
      chk("R9", $sformatf("end pulse v%0d", i), int'(end_pls), int'(TAB[i].e));
      chk("R7", $sformatf("bad v%0d", i), int'(bad_pls), int'(TAB[i].x));
      chk("R6", $sformatf("pend v%0d", i), int'(addr_pend), int'(TAB[i].p));
      if (TAB[i].b) chk("R4", $sformatf("addr v%0d", i), int'(begin_addr), int'(a));
      if (TAB[i].e) begin
        chk((TAB[i].k inside {3'd1, 3'd2, 3'd5}) ? "R1" : "R2",
            $sformatf("kind v%0d", i), int'(end_kind), int'(TAB[i].k));
        chk("R5", $sformatf("data v%0d", i), int'(end_data), int'(TAB[i].ed));
        chk("R8", $sformatf("cat v%0d", i), int'(end_cat), int'(exp_cat(TAB[i].k)));
      end
    end

    // R3: select without strobe is idle
    @(negedge clk); drive(C_MNOS, 16'h2222, 8'h12); step_check();
    chk("R3", "mem select no strobe begin", int'(begin_pls), 0);
    @(negedge clk); drive(C_INOS, 16'h3333, 8'h13); step_check();
    chk("R3", "io select no strobe begin", int'(begin_pls), 0);
    chk("R3", "io select no strobe pend", int'(addr_pend), 0);

    // R10: reset during an active cycle, then release with kind held
    @(negedge clk); drive(C_OPF, 16'hBEEF, 8'h5A); step_check();
    chk("R4", "pre-reset begin", int'(begin_pls), 1);
    @(negedge clk); rst = 1'b1; step_check();
    chk("R10", "pend in reset", int'(addr_pend), 0);
    chk("R10", "begin in reset", int'(begin_pls), 0);
    @(negedge clk); rst = 1'b0; drive(C_OPF, 16'hCAFE, 8'h5B); step_check();
    chk("R10", "fresh begin after reset", int'(begin_pls), 1);
    chk("R10", "fresh begin addr", int'(begin_addr), 16'hCAFE);
    @(negedge clk); drive(C_IDLE, 16'h0, 8'h00); step_check();
    chk("R5", "end data after reset", int'(end_data), 8'h5B);
    chk("R9", "end pulse after reset", int'(end_pls), 1);
    @(negedge clk); step_check();
    chk("R9", "end pulse single", int'(end_pls), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule